// File: doc/BRIEF.md
# Configuration-Mode Unlock Port for a Peripheral Controller

This block sits on a byte-wide I/O bus as a slave that answers at two consecutive addresses: an index port at the base address and a data port one above it. Software picks a configuration register by writing its number to the index port, then reads or writes that register through the data port. The register file stays closed until a four-byte key has been written to the index port. The last byte of that key depends on which of the two standard base ports the instance is strapped to.

Once it is open, the block exposes a read-only two-byte chip identifier, a logical-device select register, a global register of flash enable flags, and a 16-bit flash-controller base address that is visible only while logical device 7 is selected. Writing the exit value to the exit register closes the port again. The base address and the flag bits drive output pins, so the surrounding logic can use them directly.

Bus accesses are single-cycle strobes. `io_rdata` is combinational and is valid in the same cycle as `io_rd`. Write data is taken at the rising clock edge on which `io_wr` is high. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked (`cfg_open`=0), the index register holds 0x00, the logical device is 0, `flash_flags` is 0 and `flash_base` equals the `FLASH_BASE_RST` parameter.
- R2: Writing the bytes 0x87, 0x01 and 0x55 to the index port, and then a last key byte, opens the port (`cfg_open`=1). The last key byte is 0xAA when `BASE_PORT` is 0x4E and 0x55 for any other base, including 0x2E.
- R3: While the port is locked, an index-port write that does not match the expected key byte restarts the key. A mismatching byte of 0x87 counts as the first key byte; any other mismatching byte returns the matcher to the start. Data-port writes do not affect the key matcher.
- R4: Only the addresses `BASE_PORT` (index) and `BASE_PORT`+1 (data) are decoded. Reads at any other address, or with no `io_rd`, return 0xFF. While the port is open, a read of the index port returns the current index.
- R5: Register 0x20 reads the high byte of `CHIP_ID` and register 0x21 reads the low byte (0x87 and 0x16 by default). Writes to these registers change nothing.
- R6: Register 0x07 is an 8-bit, readable and writable logical-device select.
- R7: While the logical device is 7, registers 0x64 and 0x65 read and write the high and low bytes of `flash_base`. With any other logical device selected they read 0x00 and writes to them are ignored.
- R8: Register 0x24 stores bits [5:0], which drive `flash_flags`. Bit 0 is suspend, bit 1 enables the top 128 KiB segment, bits 2 and 3 enable further segments, bit 4 allows bus writes to flash and bit 5 selects the flash pin. Bits [7:6] read as 0.
- R9: Writing 0x02 to register 0x02 locks the port and returns the key matcher to the first key byte. Writing any other value to register 0x02 has no effect.
- R10: While the port is locked, data-port and index-port reads return 0xFF, and data-port writes change no register.
- R11: Registers not listed above read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the current strobe |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Single-cycle read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational, 0xFF when not driven |
| cfg_open | output | 1 | High while configuration mode is open |
| flash_base | output | 16 | Flash-controller base address |
| flash_flags | output | 6 | Flash enable flags from register 0x24 |

## Verification
The embedded assertions check on every cycle that the port opens only on the cycle after a write of the correct last key byte, that the exit write closes it, that a locked port returns 0xFF on data reads and holds all registers against data writes, that the flash base address moves only under logical device 7, and that chip-ID reads return the parameter bytes. The bench scenarios are needed for the parts that depend on history: key sequences broken in different places, including the restart on 0x87 and data writes placed inside the key, and the choice of last key byte for each base port. They also cover writes made while locked that must not show up after a later unlock, and the read-back values of every register.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] KEY_B0      = 8'h87;
  localparam logic [7:0] KEY_B1      = 8'h01;
  localparam logic [7:0] KEY_B2      = 8'h55;
  localparam logic [7:0] KEY_LAST_LO = 8'h55;
  localparam logic [7:0] KEY_LAST_HI = 8'hAA;
  localparam logic [15:0] ALT_PORT   = 16'h004E;

  localparam logic [7:0] R_EXIT     = 8'h02;
  localparam logic [7:0] R_DEVSEL   = 8'h07;
  localparam logic [7:0] R_ID_HI    = 8'h20;
  localparam logic [7:0] R_ID_LO    = 8'h21;
  localparam logic [7:0] R_FLAGS    = 8'h24;
  localparam logic [7:0] R_FBASE_HI = 8'h64;
  localparam logic [7:0] R_FBASE_LO = 8'h65;
  localparam logic [7:0] EXIT_CODE  = 8'h02;
  localparam logic [7:0] FLASH_DEV  = 8'h07;
  localparam logic [7:0] IDLE_BYTE  = 8'hFF;

  function automatic logic [7:0] last_key_for(input logic [15:0] base);
    return (base == ALT_PORT) ? KEY_LAST_HI : KEY_LAST_LO;
  endfunction
endpackage

// File: rtl/sio_key_matcher.sv
module sio_key_matcher
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] KEY_LAST = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  input  logic       exit_req,
  output logic       open
);
  logic [1:0] pos_q;
  logic [7:0] expect_b;

  always_comb begin
    unique case (pos_q)
      2'd0:    expect_b = KEY_B0;
      2'd1:    expect_b = KEY_B1;
      2'd2:    expect_b = KEY_B2;
      default: expect_b = KEY_LAST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open  <= 1'b0;
      pos_q <= 2'd0;
    end else if (!open) begin
      if (idx_wr) begin
        if (wdata == expect_b) begin
          if (pos_q == 2'd3) begin
            open  <= 1'b1;
            pos_q <= 2'd0;
          end else begin
            pos_q <= pos_q + 2'd1;
          end
        end else begin
          pos_q <= (wdata == KEY_B0) ? 2'd1 : 2'd0;
        end
      end
    end else if (exit_req) begin
      open  <= 1'b0;
      pos_q <= 2'd0;
    end
  end

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(idx_wr && wdata == KEY_LAST)) else $error("open without last key"); // R2
  AST_EXIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (open && exit_req) |=> !open) else $error("exit ignored"); // R9
  AST_EXIT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (open && exit_req) |=> pos_q == 2'd0) else $error("key not restarted"); // R9
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID        = 16'h8716,
  parameter logic [15:0] FLASH_BASE_RST = 16'h0A00,
  parameter int          FLAG_W         = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open,
  input  logic              idx_wr,
  input  logic              data_wr,
  input  logic [7:0]        wdata,
  output logic [7:0]        index,
  output logic [7:0]        rd_val,
  output logic              exit_req,
  output logic [15:0]       flash_base,
  output logic [FLAG_W-1:0] flags
);
  localparam int PAD_W = 8 - FLAG_W;

  logic [7:0] devsel_q;
  logic       wr_ok;
  logic       in_flash_dev;

  assign wr_ok        = open && data_wr;
  assign in_flash_dev = (devsel_q == FLASH_DEV);
  assign exit_req     = wr_ok && (index == R_EXIT) && (wdata == EXIT_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index      <= 8'h00;
      devsel_q   <= 8'h00;
      flags      <= '0;
      flash_base <= FLASH_BASE_RST;
    end else begin
      if (open && idx_wr) index <= wdata;
      if (wr_ok) begin
        unique case (index)
          R_DEVSEL: devsel_q <= wdata;
          R_FLAGS:  flags    <= wdata[FLAG_W-1:0];
          R_FBASE_HI: if (in_flash_dev) flash_base[15:8] <= wdata;
          R_FBASE_LO: if (in_flash_dev) flash_base[7:0]  <= wdata;
          default: ;
        endcase
      end
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        rd_val = 8'h00;
        unique case (index)
          R_ID_HI:    rd_val = CHIP_ID[15:8];
          R_ID_LO:    rd_val = CHIP_ID[7:0];
          R_DEVSEL:   rd_val = devsel_q;
          R_FLAGS:    rd_val = {{PAD_W{1'b0}}, flags};
          R_FBASE_HI: rd_val = in_flash_dev ? flash_base[15:8] : 8'h00;
          R_FBASE_LO: rd_val = in_flash_dev ? flash_base[7:0]  : 8'h00;
          default:    rd_val = 8'h00;
        endcase
      end
    end else begin : g_full
      always_comb begin
        rd_val = 8'h00;
        unique case (index)
          R_ID_HI:    rd_val = CHIP_ID[15:8];
          R_ID_LO:    rd_val = CHIP_ID[7:0];
          R_DEVSEL:   rd_val = devsel_q;
          R_FLAGS:    rd_val = flags[7:0];
          R_FBASE_HI: rd_val = in_flash_dev ? flash_base[15:8] : 8'h00;
          R_FBASE_LO: rd_val = in_flash_dev ? flash_base[7:0]  : 8'h00;
          default:    rd_val = 8'h00;
        endcase
      end
    end
  endgenerate

  AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!open && data_wr) |=> ($stable(devsel_q) && $stable(flags) && $stable(flash_base)))
    else $error("locked write changed state"); // R10
  AST_BASE_DEV7_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (devsel_q != FLASH_DEV) |=> $stable(flash_base)) else $error("base moved outside dev 7"); // R7
  AST_LOCKED_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (!open && idx_wr) |=> $stable(index)) else $error("index moved while locked"); // R3
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] BASE_PORT      = 16'h002E,
  parameter logic [15:0] CHIP_ID        = 16'h8716,
  parameter logic [15:0] FLASH_BASE_RST = 16'h0A00,
  parameter int          FLAG_W         = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              cfg_open,
  output logic [15:0]       flash_base,
  output logic [FLAG_W-1:0] flash_flags
);
  localparam logic [15:0] DATA_PORT = BASE_PORT + 16'd1;
  localparam logic [7:0]  KEY_LAST  = last_key_for(BASE_PORT);

  logic       hit_idx, hit_dat;
  logic       idx_wr, dat_wr;
  logic       exit_req;
  logic [7:0] index, rd_val;

  assign hit_idx = (io_addr == BASE_PORT);
  assign hit_dat = (io_addr == DATA_PORT);
  assign idx_wr  = io_wr && hit_idx;
  assign dat_wr  = io_wr && hit_dat;

  sio_key_matcher #(.KEY_LAST(KEY_LAST)) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (idx_wr),
    .wdata    (io_wdata),
    .exit_req (exit_req),
    .open     (cfg_open)
  );

  sio_cfg_regs #(
    .CHIP_ID        (CHIP_ID),
    .FLASH_BASE_RST (FLASH_BASE_RST),
    .FLAG_W         (FLAG_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .open       (cfg_open),
    .idx_wr     (idx_wr),
    .data_wr    (dat_wr),
    .wdata      (io_wdata),
    .index      (index),
    .rd_val     (rd_val),
    .exit_req   (exit_req),
    .flash_base (flash_base),
    .flags      (flash_flags)
  );

  always_comb begin
    io_rdata = IDLE_BYTE;
    if (io_rd && cfg_open) begin
      if (hit_idx)      io_rdata = index;
      else if (hit_dat) io_rdata = rd_val;
    end
  end

  AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !cfg_open) |-> io_rdata == IDLE_BYTE) else $error("locked read leaked"); // R10
  AST_ID_HI_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && cfg_open && hit_dat && index == R_ID_HI) |-> io_rdata == CHIP_ID[15:8])
    else $error("bad id high"); // R5
  AST_ID_LO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && cfg_open && hit_dat && index == R_ID_LO) |-> io_rdata == CHIP_ID[7:0])
    else $error("bad id low"); // R5
  AST_OFF_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_idx && !hit_dat) |-> io_rdata == IDLE_BYTE) else $error("undecoded address driven"); // R4
endmodule

// File: tb/sio_cfg_port_tb_top.sv
module sio_cfg_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  rdata_a, rdata_b;
  logic        open_a, open_b;
  logic [15:0] base_a, base_b;
  logic [5:0]  flags_a, flags_b;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int cycles = 0;

  localparam logic [15:0] PA = 16'h002E;
  localparam logic [15:0] PB = 16'h004E;
  localparam logic [15:0] RST_BASE = 16'h0A00;

  always #5 clk = ~clk;

  sio_cfg_port #(.BASE_PORT(PA), .FLASH_BASE_RST(RST_BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(rdata_a), .cfg_open(open_a),
    .flash_base(base_a), .flash_flags(flags_a));

  sio_cfg_port #(.BASE_PORT(PB), .FLASH_BASE_RST(RST_BASE)) dut_alt_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(rdata_b), .cfg_open(open_b),
    .flash_base(base_b), .flash_flags(flags_b));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    d = (a == PB || a == PB + 16'd1) ? rdata_b : rdata_a;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [15:0] p, input logic [7:0] r, input logic [7:0] d);
    wr(p, r);
    wr(p + 16'd1, d);
  endtask

  task automatic reg_rd(input logic [15:0] p, input logic [7:0] r, output logic [7:0] d);
    wr(p, r);
    rd(p + 16'd1, d);
  endtask

  task automatic unlock(input logic [15:0] p, input logic [7:0] last);
    wr(p, 8'h87); wr(p, 8'h01); wr(p, 8'h55); wr(p, last);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 open_a", {15'd0, open_a}, 16'd0);
    chk("R1 open_b", {15'd0, open_b}, 16'd0);
    chk("R1 base", base_a, RST_BASE);
    chk("R1 flags", {10'd0, flags_a}, 16'd0);
    rd(PA + 16'd1, d);
    chk("R10 locked data read", {8'd0, d}, 16'h00FF);
    rd(PA, d);
    chk("R10 locked index read", {8'd0, d}, 16'h00FF);
  endtask

  task automatic t_locked_writes();
    logic [7:0] d;
    wr(PA + 16'd1, 8'h33);
    chk("R10 locked data write base", base_a, RST_BASE);
    unlock(PA, 8'h55);
    chk("R2 open after key on 2E", {15'd0, open_a}, 16'd1);
    chk("R2 other port stays closed", {15'd0, open_b}, 16'd0);
    rd(PA, d);
    chk("R1 index reset value", {8'd0, d}, 16'h0000);
    reg_rd(PA, 8'h07, d);
    chk("R1 devsel reset 0", {8'd0, d}, 16'h0000);
    reg_wr(PA, 8'h02, 8'h02);
    chk("R9 exit closes", {15'd0, open_a}, 16'd0);
    wr(PA + 16'd1, 8'h07);
    unlock(PA, 8'h55);
    rd(PA, d);
    chk("R10 locked write did not touch index/regs", {8'd0, d}, 16'h0002);
    reg_rd(PA, 8'h07, d);
    chk("R10 devsel unchanged after locked write", {8'd0, d}, 16'h0000);
    reg_wr(PA, 8'h02, 8'h02);
  endtask

  task automatic t_port_key();
    unlock(PB, 8'h55);
    chk("R2 4E rejects 55 last", {15'd0, open_b}, 16'd0);
    unlock(PB, 8'hAA);
    chk("R2 4E opens with AA last", {15'd0, open_b}, 16'd1);
    chk("R2 2E not opened by 4E key", {15'd0, open_a}, 16'd0);
    reg_wr(PB, 8'h02, 8'h02);
    chk("R9 4E closes", {15'd0, open_b}, 16'd0);
  endtask

  task automatic t_key_breaks();
    wr(PA, 8'h87); wr(PA, 8'h01); wr(PA, 8'h00); wr(PA, 8'h55); wr(PA, 8'h55);
    chk("R3 broken key stays locked", {15'd0, open_a}, 16'd0);
    wr(PA, 8'h87); wr(PA, 8'h87); wr(PA, 8'h01); wr(PA, 8'h55); wr(PA, 8'h55);
    chk("R3 repeated 87 restarts at byte two", {15'd0, open_a}, 16'd1);
    reg_wr(PA, 8'h02, 8'h02);
    wr(PA, 8'h87); wr(PA, 8'h01);
    wr(PA + 16'd1, 8'h12);
    wr(PA, 8'h55); wr(PA, 8'h55);
    chk("R3 data write inside key ignored", {15'd0, open_a}, 16'd1);
    reg_wr(PA, 8'h02, 8'h02);
    wr(PA, 8'h87); wr(PA, 8'h01); wr(PA, 8'h55); wr(PA, 8'h87);
    wr(PA, 8'h01); wr(PA, 8'h55); wr(PA, 8'h55);
    chk("R3 87 at last slot restarts", {15'd0, open_a}, 16'd1);
    reg_wr(PA, 8'h02, 8'h02);
    wr(PA, 8'h87); wr(PA, 8'h01); wr(PA, 8'h55);
    reg_wr(PA, 8'h02, 8'h02);
    wr(PA, 8'h55);
    chk("R3 stray writes leave locked", {15'd0, open_a}, 16'd0);
  endtask

  task automatic t_registers();
    logic [7:0] d;
    unlock(PA, 8'h55);
    reg_rd(PA, 8'h20, d);
    chk("R5 id high", {8'd0, d}, 16'h0087);
    reg_rd(PA, 8'h21, d);
    chk("R5 id low", {8'd0, d}, 16'h0016);
    reg_wr(PA, 8'h20, 8'h00);
    reg_rd(PA, 8'h20, d);
    chk("R5 id read-only", {8'd0, d}, 16'h0087);
    reg_wr(PA, 8'h07, 8'h03);
    reg_rd(PA, 8'h07, d);
    chk("R6 devsel readback", {8'd0, d}, 16'h0003);
    reg_wr(PA, 8'h64, 8'h55);
    chk("R7 base held outside dev 7", base_a, RST_BASE);
    reg_rd(PA, 8'h64, d);
    chk("R7 base reads 0 outside dev 7", {8'd0, d}, 16'h0000);
    reg_wr(PA, 8'h07, 8'h07);
    reg_wr(PA, 8'h64, 8'h12);
    reg_wr(PA, 8'h65, 8'h34);
    chk("R7 base output", base_a, 16'h1234);
    reg_rd(PA, 8'h65, d);
    chk("R7 base low readback", {8'd0, d}, 16'h0034);
    reg_wr(PA, 8'h24, 8'hFF);
    chk("R8 flags output", {10'd0, flags_a}, 16'h003F);
    reg_rd(PA, 8'h24, d);
    chk("R8 flags upper bits read 0", {8'd0, d}, 16'h003F);
    reg_wr(PA, 8'h24, 8'h12);
    chk("R8 flags bits 4 and 1", {10'd0, flags_a}, 16'h0012);
    reg_wr(PA, 8'h30, 8'h5A);
    reg_rd(PA, 8'h30, d);
    chk("R11 unused reads 0", {8'd0, d}, 16'h0000);
    rd(PA, d);
    chk("R4 index readback", {8'd0, d}, 16'h0030);
    rd(16'h0050, d);
    chk("R4 undecoded address idle", {8'd0, rdata_a}, 16'h00FF);
  endtask

  task automatic t_exit();
    logic [7:0] d;
    reg_wr(PA, 8'h02, 8'h01);
    chk("R9 wrong exit value ignored", {15'd0, open_a}, 16'd1);
    reg_wr(PA, 8'h02, 8'h02);
    chk("R9 exit value locks", {15'd0, open_a}, 16'd0);
    reg_rd(PA, 8'h20, d);
    chk("R10 id hidden when locked", {8'd0, d}, 16'h00FF);
    wr(PA, 8'h55);
    chk("R9 matcher at first byte after exit", {15'd0, open_a}, 16'd0);
    chk("R7 base kept after exit", base_a, 16'h1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked_writes();
    t_port_key();
    t_key_breaks();
    t_registers();
    t_exit();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule